// File: doc/BRIEF.md
# Decode Stage Flow Controller with Group Skid Buffer

This block governs the flow of instruction groups through the decode stage of a superscalar core. Each cycle fetch may present a group of up to `W` instruction slots and a count of how many are valid. The controller passes the live instructions of that group to rename one cycle later. It packs them into the lowest output slots and reports how many there are. Instructions that carry a kill flag are dropped. Instructions with no source operands are tagged ready-to-issue on the way through.

Rename, execute and commit each have a stall input, and commit has two squash inputs. When any downstream stage stalls, the controller parks each fetch group that arrives in a small FIFO of whole groups, and it holds fetch with a stall output. Once every stall clears, it drains that FIFO at one group per cycle. Groups that arrive during the drain are added at the tail, and fetch stays held until the FIFO is empty. A commit squash empties the FIFO and holds decode quiet until both squash inputs drop. A group pushed into a full FIFO is lost, and a sticky error flag records the loss.

Top module: `decode_flow_ctrl`

## Requirements
- R1: After reset the controller is idle: `rn_cnt` is 0, `fetch_stall` is 0 and `overflow_err` is 0.
- R2: When not stalled, not squashing and not draining, a fetch group sampled at a clock edge appears on the rename outputs after that same edge. Its live instructions are packed into output slots 0 upward, in their input slot order, and `rn_cnt` gives their number. Input slot i is `fetch_data[i*DATA_W +: DATA_W]`, and only slots below `fetch_cnt` are valid.
- R3: A sampled stall from rename, execute or commit, with no commit squash, blocks the controller. No output is produced for that cycle, a valid group arriving in the same cycle is stored, and `fetch_stall` is high from the next cycle.
- R4: While blocked, every valid arriving group is stored, `rn_cnt` stays 0 and `fetch_stall` stays high.
- R5: A blocked controller starts draining once all three stall inputs are low, and `fetch_stall` stays high on that step. If nothing is stored and no group arrives, it returns straight to normal flow with `fetch_stall` low.
- R6: While draining, the controller forwards the oldest stored group each cycle, packed as in R2, and adds any arriving group at the tail. `fetch_stall` stays high until the cycle in which the last stored group is forwarded, after which it is low.
- R7: A commit squash takes priority in every state. The FIFO is emptied, nothing is forwarded, and `fetch_stall` is low in the next cycle. While blocked, the reorder-buffer-squashing input has the same effect.
- R8: While squashing, arriving groups are discarded. The controller returns to normal flow after a cycle in which both `commit_squash` and `rob_squashing` are low.
- R9: An instruction whose bit in `fetch_kill` is 1 is never forwarded, but later valid slots of the same group still are.
- R10: `rn_ready[k]` equals the `fetch_nosrc` bit of the input slot that was forwarded into output slot k.
- R11: A group pushed while the FIFO holds `DEPTH` groups and none is being removed is discarded. `overflow_err` then goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_data | input | W*DATA_W | Instruction payloads of the fetch group, slot i at i*DATA_W |
| fetch_kill | input | W | Per-slot squashed flag |
| fetch_nosrc | input | W | Per-slot flag: no source operands |
| fetch_cnt | input | CNT_W | Number of valid slots, 0 means no group |
| stall_rename | input | 1 | Stall request from rename |
| stall_exec | input | 1 | Stall request from execute |
| stall_commit | input | 1 | Stall request from commit |
| commit_squash | input | 1 | Squash request from commit |
| rob_squashing | input | 1 | Reorder buffer is still squashing |
| rn_data | output | W*DATA_W | Packed payloads to rename |
| rn_ready | output | W | Ready-to-issue tag per output slot |
| rn_cnt | output | CNT_W | Number of valid output slots |
| fetch_stall | output | 1 | Hold request to fetch |
| overflow_err | output | 1 | Sticky FIFO overflow flag |

## Verification
A wrong state shows at the ports within one or two cycles. A controller stuck in a blocked or draining state keeps `fetch_stall` high after the drain has ended. A missed squash lets a flushed group reach rename. A wrong FIFO pointer sends groups out of order or twice. A scoreboard that keeps every expected output instruction in order catches any of these as soon as the faulty output cycle appears. Direct checks of `fetch_stall` and `rn_cnt` at each step of the stall, drain and squash sequences catch faults in transition timing in the cycle where they occur.

// File: rtl/dec_flow_pkg.sv
package dec_flow_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_BLOCK = 3'd2,
    ST_UNBLK = 3'd3,
    ST_SQSH  = 3'd4
  } dstate_e;
endpackage

// File: rtl/dec_group_pack.sv
// Packs the live slots of one instruction group into the low output slots.
module dec_group_pack #(
  parameter int W      = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(W + 1)
) (
  input  logic [W*DATA_W-1:0] in_data,
  input  logic [W-1:0]        in_kill,
  input  logic [W-1:0]        in_nosrc,
  input  logic [CNT_W-1:0]    in_cnt,
  output logic [W*DATA_W-1:0] out_data,
  output logic [W-1:0]        out_rdy,
  output logic [CNT_W-1:0]    out_cnt
);
  always_comb begin
    int unsigned k;
    k        = 0;
    out_data = '0;
    out_rdy  = '0;
    for (int i = 0; i < W; i++) begin
      if ((CNT_W'(i) < in_cnt) && !in_kill[i]) begin
        out_data[k*DATA_W +: DATA_W] = in_data[i*DATA_W +: DATA_W];
        out_rdy[k]                   = in_nosrc[i];
        k                            = k + 1;
      end
    end
    out_cnt = CNT_W'(k);
  end
endmodule

// File: rtl/dec_skid_fifo.sv
// FIFO of whole fetch groups with flush and overflow pulse.
module dec_skid_fifo #(
  parameter int GRP_W = 74,
  parameter int DEPTH = 4,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [GRP_W-1:0] din,
  output logic [GRP_W-1:0] head,
  output logic             empty,
  output logic             one_left,
  output logic             ovf,
  output logic [LVL_W-1:0] level
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [GRP_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_nxt, rd_ptr_nxt;
  logic [LVL_W-1:0] level_nxt;
  logic             full, push_ok, pop_ok;

  assign full     = (level == LVL_W'(DEPTH));
  assign empty    = (level == '0);
  assign one_left = (level == LVL_W'(1));
  assign pop_ok   = pop && !empty;
  assign push_ok  = push && (!full || pop_ok);
  assign ovf      = push && full && !pop_ok && !flush;
  assign head     = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    level_nxt  = level;
    if (flush) begin
      wr_ptr_nxt = '0;
      rd_ptr_nxt = '0;
      level_nxt  = '0;
    end else begin
      if (push_ok) wr_ptr_nxt = ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr_nxt = ptr_inc(rd_ptr);
      level_nxt = level + LVL_W'(push_ok) - LVL_W'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      level  <= level_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/dec_flow_fsm.sv
// Sequencing of normal flow, blocking, draining and squashing.
module dec_flow_fsm
  import dec_flow_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fetch_vld,
  input  logic    any_stall,
  input  logic    cmt_sq,
  input  logic    rob_sq,
  input  logic    buf_empty,
  input  logic    buf_one,
  output dstate_e state,
  output logic    push,
  output logic    pop,
  output logic    flush,
  output logic    from_skid,
  output logic    fwd
);
  dstate_e nxt;

  always_comb begin
    nxt       = state;
    push      = 1'b0;
    pop       = 1'b0;
    flush     = 1'b0;
    from_skid = 1'b0;
    fwd       = 1'b0;
    case (state)
      ST_IDLE, ST_RUN: begin
        if (cmt_sq) begin
          nxt   = ST_SQSH;
          flush = 1'b1;
        end else if (any_stall) begin
          nxt  = ST_BLOCK;
          push = fetch_vld;
        end else if (fetch_vld) begin
          nxt = ST_RUN;
          fwd = 1'b1;
        end
      end
      ST_BLOCK: begin
        if (cmt_sq || rob_sq) begin
          nxt   = ST_SQSH;
          flush = 1'b1;
        end else begin
          push = fetch_vld;
          if (!any_stall)
            nxt = (buf_empty && !fetch_vld) ? ST_RUN : ST_UNBLK;
        end
      end
      ST_UNBLK: begin
        if (cmt_sq) begin
          nxt   = ST_SQSH;
          flush = 1'b1;
        end else if (any_stall) begin
          nxt  = ST_BLOCK;
          push = fetch_vld;
        end else begin
          fwd       = 1'b1;
          from_skid = 1'b1;
          pop       = 1'b1;
          push      = fetch_vld;
          nxt       = (buf_one && !fetch_vld) ? ST_RUN : ST_UNBLK;
        end
      end
      ST_SQSH: begin
        if (!cmt_sq && !rob_sq) nxt = ST_RUN;
        else if (cmt_sq)        flush = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/decode_flow_ctrl.sv
module decode_flow_ctrl
  import dec_flow_pkg::*;
#(
  parameter int W      = 4,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = $clog2(W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W*DATA_W-1:0] fetch_data,
  input  logic [W-1:0]        fetch_kill,
  input  logic [W-1:0]        fetch_nosrc,
  input  logic [CNT_W-1:0]    fetch_cnt,
  input  logic                stall_rename,
  input  logic                stall_exec,
  input  logic                stall_commit,
  input  logic                commit_squash,
  input  logic                rob_squashing,
  output logic [W*DATA_W-1:0] rn_data,
  output logic [W-1:0]        rn_ready,
  output logic [CNT_W-1:0]    rn_cnt,
  output logic                fetch_stall,
  output logic                overflow_err
);
  localparam int D_LSB = 0;
  localparam int K_LSB = W * DATA_W;
  localparam int N_LSB = K_LSB + W;
  localparam int C_LSB = N_LSB + W;
  localparam int GRP_W = C_LSB + CNT_W;
  localparam int LVL_W = $clog2(DEPTH + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic [CNT_W-1:0] cnt_clamp;
  logic             fetch_vld, any_stall;
  assign cnt_clamp = (fetch_cnt > CNT_W'(W)) ? CNT_W'(W) : fetch_cnt;
  assign fetch_vld = (cnt_clamp != '0);
  assign any_stall = stall_rename | stall_exec | stall_commit;

  logic [GRP_W-1:0] fetch_grp, head_grp, sel_grp;
  assign fetch_grp = {cnt_clamp, fetch_nosrc, fetch_kill, fetch_data};

  dstate_e          state_q;
  logic             push, pop, flush, from_skid, fwd;
  logic             buf_empty, buf_one, ovf_pulse;
  logic [LVL_W-1:0] buf_level;

  dec_flow_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_ni),
    .fetch_vld (fetch_vld),
    .any_stall (any_stall),
    .cmt_sq    (commit_squash),
    .rob_sq    (rob_squashing),
    .buf_empty (buf_empty),
    .buf_one   (buf_one),
    .state     (state_q),
    .push      (push),
    .pop       (pop),
    .flush     (flush),
    .from_skid (from_skid),
    .fwd       (fwd)
  );

  dec_skid_fifo #(.GRP_W(GRP_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_skid (
    .clk      (clk),
    .rst_n    (rst_ni),
    .push     (push),
    .pop      (pop),
    .flush    (flush),
    .din      (fetch_grp),
    .head     (head_grp),
    .empty    (buf_empty),
    .one_left (buf_one),
    .ovf      (ovf_pulse),
    .level    (buf_level)
  );

  assign sel_grp = from_skid ? head_grp : fetch_grp;

  logic [W*DATA_W-1:0] pk_data;
  logic [W-1:0]        pk_rdy;
  logic [CNT_W-1:0]    pk_cnt;

  dec_group_pack #(.W(W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_pack (
    .in_data  (sel_grp[D_LSB +: W*DATA_W]),
    .in_kill  (sel_grp[K_LSB +: W]),
    .in_nosrc (sel_grp[N_LSB +: W]),
    .in_cnt   (sel_grp[C_LSB +: CNT_W]),
    .out_data (pk_data),
    .out_rdy  (pk_rdy),
    .out_cnt  (pk_cnt)
  );

  // output register, payload loads only when a group is forwarded
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rn_cnt   <= '0;
      rn_data  <= '0;
      rn_ready <= '0;
    end else begin
      rn_cnt <= fwd ? pk_cnt : '0;
      if (fwd) begin
        rn_data  <= pk_data;
        rn_ready <= pk_rdy;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)        overflow_err <= 1'b0;
    else if (ovf_pulse) overflow_err <= 1'b1;
  end

  assign fetch_stall = (state_q == ST_BLOCK) || (state_q == ST_UNBLK);
endmodule

// File: rtl/dec_flow_ctrl_chk.sv
module dec_flow_ctrl_chk
  import dec_flow_pkg::*;
#(
  parameter int W     = 4,
  parameter int CNT_W = 3,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall_rename,
  input logic             stall_exec,
  input logic             stall_commit,
  input logic             commit_squash,
  input logic             rob_squashing,
  input logic [CNT_W-1:0] rn_cnt,
  input logic             fetch_stall,
  input logic             overflow_err,
  input dstate_e          state,
  input logic [LVL_W-1:0] buf_level
);
  logic stl;
  assign stl = stall_rename | stall_exec | stall_commit;

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rn_cnt <= CNT_W'(W));

  assert_no_out_on_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stl |=> (rn_cnt == '0));

  assert_blocked_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BLOCK && stl && !commit_squash && !rob_squashing) |=> fetch_stall);

  assert_unblock_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BLOCK && !stl && !commit_squash && !rob_squashing && buf_level != '0)
      |=> fetch_stall);

  assert_squash_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_squash |=> (rn_cnt == '0 && !fetch_stall && buf_level == '0));

  assert_squash_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SQSH && !commit_squash && !rob_squashing) |=> (state == ST_RUN));

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> overflow_err);
endmodule

bind decode_flow_ctrl dec_flow_ctrl_chk #(.W(W), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_ni),
  .stall_rename  (stall_rename),
  .stall_exec    (stall_exec),
  .stall_commit  (stall_commit),
  .commit_squash (commit_squash),
  .rob_squashing (rob_squashing),
  .rn_cnt        (rn_cnt),
  .fetch_stall   (fetch_stall),
  .overflow_err  (overflow_err),
  .state         (state_q),
  .buf_level     (buf_level)
);

// File: tb/decode_flow_ctrl_bench.sv
`timescale 1ns/1ps
module decode_flow_ctrl_bench;
  localparam int W      = 4;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = $clog2(W + 1);

  logic                clk = 1'b0;
  logic                rst_n;
  logic [W*DATA_W-1:0] fetch_data;
  logic [W-1:0]        fetch_kill, fetch_nosrc;
  logic [CNT_W-1:0]    fetch_cnt;
  logic                stall_rename, stall_exec, stall_commit;
  logic                commit_squash, rob_squashing;
  logic [W*DATA_W-1:0] rn_data;
  logic [W-1:0]        rn_ready;
  logic [CNT_W-1:0]    rn_cnt;
  logic                fetch_stall, overflow_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit live   = 1'b0;
  bit done   = 1'b0;
  logic [DATA_W:0] sb[$];

  always #2 clk = ~clk;

  decode_flow_ctrl #(.W(W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_decode_flow_ctrl (
    .clk(clk), .rst_n(rst_n),
    .fetch_data(fetch_data), .fetch_kill(fetch_kill), .fetch_nosrc(fetch_nosrc),
    .fetch_cnt(fetch_cnt),
    .stall_rename(stall_rename), .stall_exec(stall_exec), .stall_commit(stall_commit),
    .commit_squash(commit_squash), .rob_squashing(rob_squashing),
    .rn_data(rn_data), .rn_ready(rn_ready), .rn_cnt(rn_cnt),
    .fetch_stall(fetch_stall), .overflow_err(overflow_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // drive one group for one cycle; queue the forwarded items when expected
  task automatic send(input int cnt, input logic [W-1:0] kill,
                      input logic [W-1:0] nos, input int base, input bit exp);
    for (int i = 0; i < W; i++) fetch_data[i*DATA_W +: DATA_W] = DATA_W'(base + i);
    fetch_kill  = kill;
    fetch_nosrc = nos;
    fetch_cnt   = CNT_W'(cnt);
    if (exp)
      for (int i = 0; i < cnt; i++)
        if (!kill[i]) sb.push_back({DATA_W'(base + i), nos[i]});
    tick();
    fetch_cnt = '0;
  endtask

  // monitor: every forwarded item must match the scoreboard head (R2 R9 R10)
  always @(negedge clk) begin
    if (live) begin
      for (int i = 0; i < int'(rn_cnt); i++) begin
        logic [DATA_W:0] got;
        got = {rn_data[i*DATA_W +: DATA_W], rn_ready[i]};
        n_chk++;
        if (sb.size() == 0) begin
          n_fail++;
          $display("FAIL R2 unexpected item: actual %0h expected none", got);
        end else begin
          logic [DATA_W:0] want;
          want = sb.pop_front();
          if (got != want) begin
            n_fail++;
            $display("FAIL R2/R9/R10 item: actual %0h expected %0h", got, want);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    fetch_data = '0; fetch_kill = '0; fetch_nosrc = '0; fetch_cnt = '0;
    stall_rename = 0; stall_exec = 0; stall_commit = 0;
    commit_squash = 0; rob_squashing = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    live = 1'b1;
    // R1
    chk("R1 rn_cnt", int'(rn_cnt), 0);
    chk("R1 fetch_stall", int'(fetch_stall), 0);
    chk("R1 overflow_err", int'(overflow_err), 0);

    // R2 R9 R10: normal flow
    send(4, 4'b0000, 4'b1010, 'h100, 1);
    chk("R2 full group count", int'(rn_cnt), 4);
    send(4, 4'b0101, 4'b0011, 'h200, 1);
    chk("R9 killed slots skipped", int'(rn_cnt), 2);
    send(3, 4'b1000, 4'b0100, 'h300, 1);
    chk("R2 partial group count", int'(rn_cnt), 3);
    send(2, 4'b0011, 4'b0011, 'h380, 1);
    chk("R9 all killed", int'(rn_cnt), 0);
    tick();

    // R3 R4 R5 R6: block, collect, drain
    stall_exec = 1;
    send(4, 4'b0000, 4'b0001, 'h400, 1);
    chk("R3 fetch_stall after stall", int'(fetch_stall), 1);
    chk("R3 no output", int'(rn_cnt), 0);
    send(2, 4'b0000, 4'b0010, 'h500, 1);
    chk("R4 still stalled", int'(fetch_stall), 1);
    chk("R4 no output", int'(rn_cnt), 0);
    stall_exec = 0; stall_rename = 1;
    tick();
    chk("R4 rename stall holds", int'(fetch_stall), 1);
    stall_rename = 0;
    tick();
    chk("R5 stall held into drain", int'(fetch_stall), 1);
    chk("R5 no output on release", int'(rn_cnt), 0);
    tick();
    chk("R6 first stored group", int'(rn_cnt), 4);
    chk("R6 stall while stored left", int'(fetch_stall), 1);
    send(3, 4'b0000, 4'b0000, 'h600, 1);
    chk("R6 second stored group", int'(rn_cnt), 2);
    chk("R6 appended keeps stall", int'(fetch_stall), 1);
    tick();
    chk("R6 appended group", int'(rn_cnt), 3);
    chk("R6 stall drops when empty", int'(fetch_stall), 0);

    // R5: blocked with nothing stored goes straight back
    stall_commit = 1;
    tick();
    stall_commit = 0;
    tick();
    chk("R5 empty unblock", int'(fetch_stall), 0);
    send(1, 4'b0000, 4'b0001, 'h680, 1);
    chk("R5 flow resumes", int'(rn_cnt), 1);

    // R7 R8: squash from normal flow
    commit_squash = 1;
    send(4, 4'b0000, 4'b0000, 'h700, 0);
    chk("R7 squash no output", int'(rn_cnt), 0);
    chk("R7 squash no stall", int'(fetch_stall), 0);
    commit_squash = 0; rob_squashing = 1;
    send(2, 4'b0000, 4'b0000, 'h780, 0);
    chk("R8 group dropped", int'(rn_cnt), 0);
    rob_squashing = 0;
    tick();
    send(1, 4'b0000, 4'b0001, 'h800, 1);
    chk("R8 back to flow", int'(rn_cnt), 1);

    // R7: squash while blocked empties the FIFO
    stall_exec = 1;
    send(4, 4'b0000, 4'b0000, 'h900, 0);
    send(3, 4'b0000, 4'b0000, 'hA00, 0);
    rob_squashing = 1;
    tick();
    chk("R7 squash in blocked", int'(fetch_stall), 0);
    rob_squashing = 0; stall_exec = 0;
    repeat (4) tick();
    chk("R7 flushed groups absent", int'(rn_cnt), 0);
    chk("R7 scoreboard empty", sb.size(), 0);

    // R11: overflow
    stall_exec = 1;
    send(4, 4'b0000, 4'b0000, 'hB00, 1);
    send(4, 4'b0000, 4'b0000, 'hC00, 1);
    send(4, 4'b0000, 4'b0000, 'hD00, 1);
    send(4, 4'b0000, 4'b0000, 'hE00, 1);
    chk("R11 no error at depth", int'(overflow_err), 0);
    send(4, 4'b0000, 4'b0000, 'hF00, 0);
    chk("R11 error on overflow", int'(overflow_err), 1);
    stall_exec = 0;
    repeat (8) tick();
    chk("R11 error sticky", int'(overflow_err), 1);
    chk("R11 drained", int'(fetch_stall), 0);
    chk("R11 dropped group absent", sb.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule